// File: doc/BRIEF.md
# Consecutive-Ones Serial Run Detector

This block watches a serial bit stream, one bit per clock. It reports how long the current unbroken run of ones is. A four-state Moore machine holds the run length in two register bits. The length counts up on each 1 and saturates at "three or more". Any 0 returns it to idle.

Two flags are decoded from the registered state alone, never from the live input:

- `run2_flag` marks a run that is exactly two ones long.
- `run3_flag` marks a run of three or more ones.

Each flag's value after a clock edge describes the stream up to and including the bit sampled at that edge.

The reset input is asynchronous and active low. Asserting it clears the state at once. Its release is synchronised inside the block by a short flop chain, so counting starts a fixed number of edges after `rst_n` rises.

Top module: `consec_ones_detector`

## Requirements
- R1: While `rst_n` is low, both flags are 0, whatever `ser_in` does. Asserting `rst_n` clears the flags without waiting for a clock edge.
- R2: After any edge that samples `ser_in`=0, both flags are 0.
- R3: After an edge that samples the first 1 following a 0 or reset, both flags are 0.
- R4: After an edge that samples the second consecutive 1, `run2_flag`=1 and `run3_flag`=0.
- R5: After an edge that samples the third or a later consecutive 1, `run3_flag`=1 and `run2_flag`=0. The state stays there for as long as ones continue.
- R6: The two flags are never 1 at the same time.
- R7: The flags change only at clock edges. A change of `ser_in` between edges leaves them untouched.
- R8: After reset, the stream 0,1,1,1,1,0,0,1,1 gives these values after each edge:
  - `run3_flag` = 0,0,0,1,1,0,0,0,0
  - `run2_flag` = 0,0,1,0,0,0,0,0,1
- R9: Over an arbitrary bit stream, both flags match a saturating run-length reference after every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| ser_in | input | 1 | Serial data bit, sampled on each rising edge |
| run3_flag | output | 1 | Current run of ones is three or longer |
| run2_flag | output | 1 | Current run of ones is exactly two |

## Verification
A wrong state shows at the ports within at most three edges.

- A 0 at the input flushes any error at the next edge.
- A state that has stepped wrongly under a run of ones shows as a flag that is set too early, too late, or never.
- A state stuck in the "one seen" code stays invisible until the next 1 arrives. The random stream therefore relies on many short runs to expose it.

Checks between edges, made after the input has moved, catch any leak of the live input into the flags.

// File: rtl/consec_ones_pkg.sv
package consec_ones_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b10,
    ST_MANY = 2'b11
  } run_state_e;
endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/run_next_state.sv
module run_next_state
  import consec_ones_pkg::*;
(
  input  run_state_e cur_state,
  input  logic       bit_in,
  output run_state_e nxt_state
);
  logic s1, s0;

  always_comb begin
    s1 = cur_state[1];
    s0 = cur_state[0];
    nxt_state = run_state_e'({bit_in & (s1 | s0), bit_in & (s1 | ~s0)});
  end
endmodule

// File: rtl/run_state_reg.sv
module run_state_reg
  import consec_ones_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_en,
  input  run_state_e nxt_state,
  output run_state_e cur_state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_state <= ST_IDLE;
    else if (upd_en) cur_state <= nxt_state;
  end
endmodule

// File: rtl/run_flag_decode.sv
module run_flag_decode
  import consec_ones_pkg::*;
(
  input  run_state_e cur_state,
  output logic       run3_flag,
  output logic       run2_flag
);
  always_comb begin
    run3_flag = cur_state[1] &  cur_state[0];
    run2_flag = cur_state[1] & ~cur_state[0];
  end
endmodule

// File: rtl/consec_ones_detector.sv
module consec_ones_detector
  import consec_ones_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic run3_flag,
  output logic run2_flag
);
  logic       rst_sync_n;
  run_state_e cur_state;
  run_state_e nxt_state;

  rst_release_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  run_next_state u_next (
    .cur_state (cur_state),
    .bit_in    (ser_in),
    .nxt_state (nxt_state)
  );

  run_state_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .upd_en    (1'b1),
    .nxt_state (nxt_state),
    .cur_state (cur_state)
  );

  run_flag_decode u_dec (
    .cur_state (cur_state),
    .run3_flag (run3_flag),
    .run2_flag (run2_flag)
  );

  // R2
  zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ser_in |=> (!run3_flag && !run2_flag));

  // R3
  first_one_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ser_in && cur_state == ST_IDLE) |=> (cur_state == ST_ONE && !run2_flag && !run3_flag));

  // R4
  second_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ser_in && cur_state == ST_ONE) |=> (run2_flag && !run3_flag));

  // R5
  many_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ser_in && (run2_flag || run3_flag)) |=> (run3_flag && !run2_flag));

  // R6
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({run3_flag, run2_flag}));
endmodule

// File: tb/consec_ones_detector_bench.sv
module consec_ones_detector_bench;
  localparam time TCLK = 8ns;
  localparam int  NVEC = 9;
  localparam int  NRAND = 3000;
  // each entry: {ser_in, expected run3_flag, expected run2_flag} (R8)
  localparam logic [2:0] VEC [NVEC] = '{
    3'b0_0_0, 3'b1_0_0, 3'b1_0_1, 3'b1_1_0, 3'b1_1_0,
    3'b0_0_0, 3'b0_0_0, 3'b1_0_0, 3'b1_0_1
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ser_in;
  logic run3_flag, run2_flag;
  int   checks = 0;
  int   fails  = 0;
  int   run_len = 0;

  always #(TCLK/2) clk = ~clk;

  consec_ones_detector u_consec_ones_detector (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .run3_flag (run3_flag),
    .run2_flag (run2_flag)
  );

  task automatic check(input logic e3, input logic e2, input string req);
    checks++;
    if (run3_flag !== e3 || run2_flag !== e2) begin
      fails++;
      $display("FAIL %s: got run3=%b run2=%b, expected run3=%b run2=%b",
               req, run3_flag, run2_flag, e3, e2);
    end
  endtask

  task automatic step(input logic b);
    ser_in = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_rst();
    ser_in = 1'b0;
    rst_n  = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(TCLK * 200000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ser_in = 1'b0;
    repeat (2) @(negedge clk);
    check(1'b0, 1'b0, "R1");
    ser_in = 1'b1;
    repeat (4) @(negedge clk);
    check(1'b0, 1'b0, "R1 ones held in reset");
    release_rst();
    check(1'b0, 1'b0, "R1 after release");

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][2]);
      check(VEC[i][1], VEC[i][0], "R8");
    end

    run_len = 2;
    for (int i = 0; i < NRAND; i++) begin
      logic b;
      logic e3, e2;
      b = 1'($urandom & 1);
      run_len = b ? ((run_len < 3) ? run_len + 1 : 3) : 0;
      e3 = (run_len == 3);
      e2 = (run_len == 2);
      step(b);
      if (!b)                check(e3, e2, "R2");
      else if (run_len == 1) check(e3, e2, "R3");
      else if (run_len == 2) check(e3, e2, "R4");
      else                   check(e3, e2, "R5 R9");
      if (i % 16 == 0) begin
        ser_in = ~b;
        #1;
        check(e3, e2, "R7 input moved between edges");
        ser_in = b;
      end
    end

    step(1'b0);
    for (int i = 0; i < 6; i++) step(1'b1);
    check(1'b1, 1'b0, "R5 long run saturates");
    #1;
    rst_n = 1'b0;
    #1;
    check(1'b0, 1'b0, "R1 async clear");
    @(negedge clk);
    release_rst();
    step(1'b1);
    check(1'b0, 1'b0, "R3 after reset");
    step(1'b1);
    check(1'b0, 1'b1, "R4 after reset");
    step(1'b0);
    check(1'b0, 1'b0, "R2 after two");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule